// File: doc/BRIEF.md
# Boot Source Selection Controller

This controller settles, right after reset is released, where the processor takes its first program image from. On the first clock edge after reset it samples the two boot-mode pins. It combines them with a set of static one-time-fuse flags to pick an effective boot mode, and it latches a 24-bit boot configuration word. That word comes either from external strap pins or from the fuse configuration word. The strap pins are read on that one edge only, so the strap circuit can be disconnected afterwards.

The controller then walks a fallback chain. It requests a load from the primary device and waits for a completion report or a programmable cycle timeout. If that attempt fails it requests the secondary device. After that it falls back to polling the serial links. A manufacture path probes an active-low card detect and tries the SD card first. Fuse flags can block serial download entirely or mask only the UART links.

When an image is accepted, a one-cycle jump pulse is issued with the device that supplied it. The block then stays done until the next reset. The loaders themselves, image parsing and fuse programming are outside the block.

Top module: `boot_sel_ctrl`

## Requirements
- R1: The boot pins are sampled on the first clock edge after reset release. Their encoding is 00 fuse boot, 01 serial download, 10 internal boot and 11 reserved. Reserved acts as serial download and sets `mode_err`, unless internal boot is forced.
- R2: With `fuse_force_int` at 1, internal boot is used whatever the pins say.
- R3: In internal boot with `fuse_cfg_from_fuse` at 0, `cfg_word` takes `strap_cfg`. In every other case it takes `fuse_cfg`. In the configuration word, bits [2:0] name the primary device and bits [5:3] name the secondary device. Device codes are 0 none, 1 SD, 2 NAND, 3 NOR, 4 USB, 5 UART1 and 6 UART2.
- R4: `strap_cfg` is read only on the decision edge. Later changes leave `cfg_word` unchanged.
- R5: In fuse boot with `fuse_mfg_off` at 0, the block checks `card_det_n`. A value of 0 requests an SD load, which has no secondary device. A value of 1 goes straight to serial download, and so does a failed SD load.
- R6: Serial download holds `polling` high until a link in `ser_link` reports a connection. The link bits are bit 0 USB, bit 1 UART1 and bit 2 UART2. When more than one link is connected, the lowest bit wins.
- R7: `fuse_sdp_off` at 1 replaces every entry into serial download with `boot_fail`. `fuse_uart_dl_off` at 1 masks the UART links.
- R8: A failed primary attempt requests the secondary device, if one is named. A failed last attempt enters serial download. A primary code of 0 enters serial download at once.
- R9: An image is accepted when `ld_ok` is 1 and either `ld_auth_ok` is 1 or `fuse_sec_mode` is 01. Any other outcome counts as a failure.
- R10: An attempt with no `ld_done` within `tmo_limit` cycles of its wait phase fails. With `tmo_limit` at 4, the next request follows 5 cycles after the previous one. A report in the expiry cycle wins over the timeout.
- R11: `load_req` and `jump` are single-cycle pulses, and `sel_dev` names the device during each pulse. After `jump`, `boot_done` stays high and no further request is issued until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boot_pins | input | 2 | Boot-mode pins |
| fuse_force_int | input | 1 | Force internal boot |
| fuse_cfg_from_fuse | input | 1 | Take configuration from fuses rather than straps |
| fuse_mfg_off | input | 1 | Disable the manufacture card probe |
| fuse_sdp_off | input | 1 | Block serial download |
| fuse_uart_dl_off | input | 1 | Mask the UART download links |
| fuse_sec_mode | input | 2 | Security mode; 01 accepts images that fail authentication |
| fuse_cfg | input | 24 | Fuse configuration word |
| strap_cfg | input | 24 | Strap-pin configuration word |
| card_det_n | input | 1 | Card detect, 0 = present |
| tmo_limit | input | 16 | Attempt timeout in cycles |
| ld_done | input | 1 | Loader finished the current attempt |
| ld_ok | input | 1 | Image retrieved |
| ld_auth_ok | input | 1 | Image authenticated |
| ser_link | input | 3 | Serial link connected flags |
| load_req | output | 1 | Load request pulse |
| sel_dev | output | 3 | Selected device code |
| cfg_word | output | 24 | Latched configuration word |
| polling | output | 1 | Serial download active |
| jump | output | 1 | Jump pulse |
| boot_done | output | 1 | Boot finished |
| mode_err | output | 1 | Reserved pin code seen |
| boot_fail | output | 1 | No boot path left |

## Verification
A loader report and the timeout expiry can fall in the same cycle of a wait phase. The bench provokes this by counting the cycles from the request and raising `ld_done` with an accepted image exactly on the expiry edge. The report must win: `jump` must follow with the secondary device, and neither a new request nor polling may appear. The surrounding cycles are checked as well, so an early expiry or a timeout that overrides the report is caught.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

  localparam logic [2:0] DEV_NONE  = 3'd0;
  localparam logic [2:0] DEV_SD    = 3'd1;
  localparam logic [2:0] DEV_NAND  = 3'd2;
  localparam logic [2:0] DEV_NOR   = 3'd3;
  localparam logic [2:0] DEV_USB   = 3'd4;
  localparam logic [2:0] DEV_UART1 = 3'd5;
  localparam logic [2:0] DEV_UART2 = 3'd6;

  localparam logic [1:0] MODE_FUSE     = 2'd0;
  localparam logic [1:0] MODE_SERIAL   = 2'd1;
  localparam logic [1:0] MODE_INTERNAL = 2'd2;
  localparam logic [1:0] MODE_RSVD     = 2'd3;

  typedef enum logic [1:0] {ACT_LOAD, ACT_SERIAL, ACT_FAIL} act_e;

  // Effective mode: forced internal wins, reserved folds into serial.
  function automatic logic [1:0] eff_mode(logic [1:0] pins, logic force_int);
    if (force_int) return MODE_INTERNAL;
    if (pins == MODE_RSVD) return MODE_SERIAL;
    return pins;
  endfunction

  function automatic act_e serial_or_fail(logic sdp_off);
    return sdp_off ? ACT_FAIL : ACT_SERIAL;
  endfunction

  // Image acceptance under the security mode.
  function automatic logic image_accept(logic ok, logic auth, logic [1:0] sec);
    return ok && (auth || sec == 2'b01);
  endfunction

endpackage

// File: rtl/boot_mode_decode.sv
module boot_mode_decode
  import boot_sel_pkg::*;
#(
  parameter int CFG_W = 24,
  parameter int PRI_LSB = 0
) (
  input  logic [1:0]       pins,
  input  logic             force_int,
  input  logic             cfg_from_fuse,
  input  logic             mfg_off,
  input  logic             card_n,
  input  logic             sdp_off,
  input  logic [CFG_W-1:0] fuse_cfg,
  input  logic [CFG_W-1:0] strap_cfg,
  output act_e             act,
  output logic [2:0]       first_dev,
  output logic [CFG_W-1:0] cfg,
  output logic             sd_path,
  output logic             rsvd
);
  logic [1:0] mode;

  assign mode = eff_mode(pins, force_int);
  assign cfg  = (mode == MODE_INTERNAL && !cfg_from_fuse) ? strap_cfg : fuse_cfg;
  assign rsvd = !force_int && (pins == MODE_RSVD);

  always_comb begin
    sd_path   = 1'b0;
    first_dev = DEV_NONE;
    act       = serial_or_fail(sdp_off);
    if (mode == MODE_SERIAL) begin
      act = serial_or_fail(sdp_off);
    end else if (mode == MODE_FUSE && !mfg_off) begin
      sd_path = 1'b1;
      if (!card_n) begin
        act       = ACT_LOAD;
        first_dev = DEV_SD;
      end
    end else begin
      first_dev = cfg[PRI_LSB +: 3];
      if (first_dev != DEV_NONE) act = ACT_LOAD;
    end
  end
endmodule

// File: rtl/boot_attempt_timer.sv
module boot_attempt_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (!run) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  assign expired = run && (({1'b0, cnt} + 1'b1) >= {1'b0, limit});
endmodule

// File: rtl/boot_serial_pick.sv
module boot_serial_pick
  import boot_sel_pkg::*;
#(
  parameter int N_LINK = 3
) (
  input  logic [N_LINK-1:0] link,
  input  logic              uart_off,
  output logic              valid,
  output logic [2:0]        dev
);
  logic [N_LINK-1:0] allowed;

  // Link 0 is USB; every higher link is a UART that the mask can remove.
  for (genvar g = 0; g < N_LINK; g++) begin : g_mask
    if (g == 0) begin : g_usb
      assign allowed[g] = link[g];
    end else begin : g_uart
      assign allowed[g] = link[g] && !uart_off;
    end
  end

  always_comb begin
    valid = 1'b0;
    dev   = DEV_NONE;
    for (int i = N_LINK - 1; i >= 0; i--) begin
      if (allowed[i]) begin
        valid = 1'b1;
        dev   = DEV_USB + 3'(i);
      end
    end
  end
endmodule

// File: rtl/boot_sel_ctrl.sv
module boot_sel_ctrl
  import boot_sel_pkg::*;
#(
  parameter int CFG_W = 24,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       boot_pins,
  input  logic             fuse_force_int,
  input  logic             fuse_cfg_from_fuse,
  input  logic             fuse_mfg_off,
  input  logic             fuse_sdp_off,
  input  logic             fuse_uart_dl_off,
  input  logic [1:0]       fuse_sec_mode,
  input  logic [CFG_W-1:0] fuse_cfg,
  input  logic [CFG_W-1:0] strap_cfg,
  input  logic             card_det_n,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             ld_done,
  input  logic             ld_ok,
  input  logic             ld_auth_ok,
  input  logic [2:0]       ser_link,
  output logic             load_req,
  output logic [2:0]       sel_dev,
  output logic [CFG_W-1:0] cfg_word,
  output logic             polling,
  output logic             jump,
  output logic             boot_done,
  output logic             mode_err,
  output logic             boot_fail
);
  localparam int PRI_LSB = 0;
  localparam int SEC_LSB = 3;
  localparam int N_LINK  = 3;

  typedef enum logic [2:0] {
    S_DECIDE, S_REQ, S_WAIT, S_SERIAL, S_JUMP, S_DONE, S_FAIL
  } state_e;

  state_e           st;
  logic [2:0]       sel_q;
  logic [CFG_W-1:0] cfg_q;
  logic             err_q, slot_q, sd_q;

  act_e             dec_act;
  logic [2:0]       dec_dev;
  logic [CFG_W-1:0] dec_cfg;
  logic             dec_sd, dec_rsvd;
  logic             tmo_exp;
  logic             pick_valid;
  logic [2:0]       pick_dev;
  logic [2:0]       sec_dev;

  // Named internal events, observed by the checker.
  logic decided, in_wait, ev_done_ok, ev_attempt_fail, ev_ser_grant;

  boot_mode_decode #(.CFG_W(CFG_W), .PRI_LSB(PRI_LSB)) u_dec (
    .pins(boot_pins), .force_int(fuse_force_int), .cfg_from_fuse(fuse_cfg_from_fuse),
    .mfg_off(fuse_mfg_off), .card_n(card_det_n), .sdp_off(fuse_sdp_off),
    .fuse_cfg(fuse_cfg), .strap_cfg(strap_cfg),
    .act(dec_act), .first_dev(dec_dev), .cfg(dec_cfg), .sd_path(dec_sd), .rsvd(dec_rsvd)
  );

  boot_attempt_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(in_wait), .limit(tmo_limit), .expired(tmo_exp)
  );

  boot_serial_pick #(.N_LINK(N_LINK)) u_pick (
    .link(ser_link), .uart_off(fuse_uart_dl_off), .valid(pick_valid), .dev(pick_dev)
  );

  assign sec_dev         = cfg_q[SEC_LSB +: 3];
  assign decided         = (st != S_DECIDE);
  assign in_wait         = (st == S_WAIT);
  assign ev_done_ok      = in_wait && ld_done && image_accept(ld_ok, ld_auth_ok, fuse_sec_mode);
  assign ev_attempt_fail = in_wait && (ld_done ? !image_accept(ld_ok, ld_auth_ok, fuse_sec_mode)
                                               : tmo_exp);
  assign ev_ser_grant    = (st == S_SERIAL) && pick_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_DECIDE;
      sel_q  <= DEV_NONE;
      cfg_q  <= '0;
      err_q  <= 1'b0;
      slot_q <= 1'b0;
      sd_q   <= 1'b0;
    end else begin
      case (st)
        S_DECIDE: begin
          cfg_q  <= dec_cfg;
          err_q  <= dec_rsvd;
          sd_q   <= dec_sd;
          slot_q <= 1'b0;
          case (dec_act)
            ACT_LOAD:   begin st <= S_REQ; sel_q <= dec_dev; end
            ACT_SERIAL: st <= S_SERIAL;
            default:    st <= S_FAIL;
          endcase
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: begin
          if (ev_done_ok) begin
            st <= S_JUMP;
          end else if (ev_attempt_fail) begin
            if (!slot_q && !sd_q && sec_dev != DEV_NONE) begin
              st     <= S_REQ;
              slot_q <= 1'b1;
              sel_q  <= sec_dev;
            end else begin
              st    <= (serial_or_fail(fuse_sdp_off) == ACT_FAIL) ? S_FAIL : S_SERIAL;
              sel_q <= DEV_NONE;
            end
          end
        end
        S_SERIAL: begin
          if (ev_ser_grant) begin
            st    <= S_JUMP;
            sel_q <= pick_dev;
          end
        end
        S_JUMP:  st <= S_DONE;
        default: st <= st;
      endcase
    end
  end

  assign load_req  = (st == S_REQ);
  assign sel_dev   = sel_q;
  assign cfg_word  = cfg_q;
  assign polling   = (st == S_SERIAL);
  assign jump      = (st == S_JUMP);
  assign boot_done = (st == S_DONE);
  assign mode_err  = err_q;
  assign boot_fail = (st == S_FAIL);
endmodule

// File: rtl/boot_sel_ctrl_chk.sv
module boot_sel_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fuse_sdp_off,
  input logic       fuse_uart_dl_off,
  input logic       load_req,
  input logic [2:0] sel_dev,
  input logic [23:0] cfg_word,
  input logic       polling,
  input logic       jump,
  input logic       boot_done,
  input logic       decided,
  input logic       in_wait,
  input logic       ev_attempt_fail,
  input logic       ev_ser_grant,
  input logic [2:0] pick_dev
);
  // R11: jump lasts one cycle
  p_jump_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n) jump |=> !jump);
  // R11: request lasts one cycle
  p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n) load_req |=> !load_req);
  // R11: done holds until reset
  p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n) boot_done |=> boot_done);
  // R4: configuration frozen after the decision
  p_cfg_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    decided && $past(decided) |-> $stable(cfg_word));
  // R7: serial blocked entirely
  p_sdp_block_r7: assert property (@(posedge clk) disable iff (!rst_n) fuse_sdp_off |-> !polling);
  // R7: UART masked grants only USB
  p_uart_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ser_grant && fuse_uart_dl_off |-> pick_dev == 3'd4);
  // R8: device held during an attempt
  p_dev_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait && $past(in_wait) |-> $stable(sel_dev));
  // R10: a failure only ends a wait phase
  p_fail_in_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_attempt_fail |-> in_wait && !load_req);
endmodule

bind boot_sel_ctrl boot_sel_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fuse_sdp_off(fuse_sdp_off), .fuse_uart_dl_off(fuse_uart_dl_off),
  .load_req(load_req), .sel_dev(sel_dev), .cfg_word(cfg_word), .polling(polling),
  .jump(jump), .boot_done(boot_done), .decided(decided), .in_wait(in_wait),
  .ev_attempt_fail(ev_attempt_fail), .ev_ser_grant(ev_ser_grant), .pick_dev(pick_dev)
);

// File: tb/boot_sel_ctrl_test.sv
`timescale 1ns/1ps
module boot_sel_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] boot_pins = 2'b00;
  logic fuse_force_int = 0, fuse_cfg_from_fuse = 0, fuse_mfg_off = 0;
  logic fuse_sdp_off = 0, fuse_uart_dl_off = 0;
  logic [1:0] fuse_sec_mode = 2'b00;
  logic [23:0] fuse_cfg = 24'h710003;   // primary NOR, no secondary
  logic [23:0] strap_cfg = 24'h3C001A;  // primary NAND, secondary NOR
  logic card_det_n = 1'b1;
  logic [15:0] tmo_limit = 16'd1000;
  logic ld_done = 0, ld_ok = 0, ld_auth_ok = 0;
  logic [2:0] ser_link = 3'b000;
  logic load_req, polling, jump, boot_done, mode_err, boot_fail;
  logic [2:0] sel_dev;
  logic [23:0] cfg_word;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  boot_sel_ctrl uut (
    .clk(clk), .rst_n(rst_n), .boot_pins(boot_pins), .fuse_force_int(fuse_force_int),
    .fuse_cfg_from_fuse(fuse_cfg_from_fuse), .fuse_mfg_off(fuse_mfg_off),
    .fuse_sdp_off(fuse_sdp_off), .fuse_uart_dl_off(fuse_uart_dl_off),
    .fuse_sec_mode(fuse_sec_mode), .fuse_cfg(fuse_cfg), .strap_cfg(strap_cfg),
    .card_det_n(card_det_n), .tmo_limit(tmo_limit), .ld_done(ld_done), .ld_ok(ld_ok),
    .ld_auth_ok(ld_auth_ok), .ser_link(ser_link), .load_req(load_req), .sel_dev(sel_dev),
    .cfg_word(cfg_word), .polling(polling), .jump(jump), .boot_done(boot_done),
    .mode_err(mode_err), .boot_fail(boot_fail)
  );

  task automatic chk(bit cond, string req, string what, int act, int exp);
    n_run++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);  // first edge after release has made the decision
  endtask

  task automatic respond(bit ok, bit auth);
    @(negedge clk);
    ld_done = 1'b1; ld_ok = ok; ld_auth_ok = auth;
    @(negedge clk);
    ld_done = 1'b0;
  endtask

  function automatic int outcome();
    if (load_req) return 16 + int'(sel_dev);
    if (polling) return 1;
    if (boot_fail) return 2;
    return 0;
  endfunction

  // Expected first action, computed from the requirement text.
  function automatic int expect_first(int pins, int frc, int sel, int mfg, int card, int sdp);
    int mode;
    int prim;
    int serial_code;
    serial_code = sdp ? 2 : 1;
    mode = frc ? 2 : (pins == 3 ? 1 : pins);
    if (mode == 1) return serial_code;
    if (mode == 0 && mfg == 0) return card == 0 ? 16 + 1 : serial_code;
    prim = ((mode == 2 && sel == 0) ? int'(strap_cfg) : int'(fuse_cfg)) % 8;
    return prim == 0 ? serial_code : 16 + prim;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    // Reset state
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!load_req && !jump && !boot_done && !polling && !boot_fail, "R11", "reset idle",
        outcome(), 0);

    // Near-exhaustive sweep of the decision (R1, R2, R3, R5, R7)
    for (int p = 0; p < 4; p++)
      for (int f = 0; f < 2; f++)
        for (int s = 0; s < 2; s++)
          for (int m = 0; m < 2; m++)
            for (int c = 0; c < 2; c++)
              for (int d = 0; d < 2; d++) begin
                int e;
                int ecfg;
                boot_pins = 2'(p); fuse_force_int = f[0]; fuse_cfg_from_fuse = s[0];
                fuse_mfg_off = m[0]; card_det_n = c[0]; fuse_sdp_off = d[0];
                do_reset();
                e = expect_first(p, f, s, m, c, d);
                chk(outcome() == e, "R1 R2 R5 R7", "first action", outcome(), e);
                ecfg = (f == 1 || p == 2) && s == 0 ? int'(strap_cfg) : int'(fuse_cfg);
                chk(int'(cfg_word) == ecfg, "R3", "config source", int'(cfg_word), ecfg);
                chk(mode_err == (f == 0 && p == 3), "R1", "reserved flag", mode_err,
                    (f == 0 && p == 3));
              end
    fuse_sdp_off = 0; fuse_mfg_off = 0;

    // Primary fail -> secondary, strap change ignored, jump (R8, R4, R11)
    fuse_force_int = 1; fuse_cfg_from_fuse = 0; fuse_sec_mode = 2'b00;
    do_reset();
    chk(load_req && sel_dev == 3'd2, "R8", "primary NAND", int'(sel_dev), 2);
    respond(0, 1);
    chk(load_req && sel_dev == 3'd3, "R8", "secondary NOR", int'(sel_dev), 3);
    strap_cfg = 24'h000011;
    respond(1, 1);
    chk(jump && sel_dev == 3'd3, "R11", "jump with NOR", int'(sel_dev), 3);
    chk(cfg_word == 24'h3C001A, "R4", "strap ignored", int'(cfg_word), 24'h3C001A);
    @(negedge clk);
    chk(!jump && boot_done, "R11", "single jump pulse", jump, 0);
    repeat (6) @(negedge clk);
    chk(boot_done && !load_req && !jump, "R11", "done holds", boot_done, 1);
    strap_cfg = 24'h3C001A;

    // Security mode (R9)
    fuse_sec_mode = 2'b01;
    do_reset();
    respond(1, 0);
    chk(jump && sel_dev == 3'd2, "R9", "auth fail accepted in mode 01", int'(sel_dev), 2);
    fuse_sec_mode = 2'b10;
    do_reset();
    respond(1, 0);
    chk(load_req && sel_dev == 3'd3, "R9", "auth fail rejected", outcome(), 16 + 3);

    // Both fail -> serial; UART mask; USB grant (R8, R7, R6)
    fuse_sec_mode = 2'b00;
    do_reset();
    respond(0, 0);
    respond(0, 0);
    chk(polling, "R8", "last failure enters serial", outcome(), 1);
    fuse_uart_dl_off = 1; ser_link = 3'b110;
    repeat (5) @(negedge clk);
    chk(polling && !jump, "R7", "UART links masked", outcome(), 1);
    ser_link = 3'b111;
    @(negedge clk);
    chk(jump && sel_dev == 3'd4, "R6", "USB connection", int'(sel_dev), 4);
    fuse_uart_dl_off = 0; ser_link = 3'b000;

    // Serial polling and priority (R6)
    fuse_force_int = 0; boot_pins = 2'b01;
    do_reset();
    repeat (20) @(negedge clk);
    chk(polling && !jump, "R6", "polls with no link", outcome(), 1);
    ser_link = 3'b110;
    do_reset();
    @(negedge clk);
    chk(jump && sel_dev == 3'd5, "R6", "UART1 over UART2", int'(sel_dev), 5);
    ser_link = 3'b100;
    do_reset();
    @(negedge clk);
    chk(jump && sel_dev == 3'd6, "R6", "UART2 alone", int'(sel_dev), 6);
    ser_link = 3'b000;

    // Manufacture SD failure goes to serial (R5)
    boot_pins = 2'b00; fuse_mfg_off = 0; card_det_n = 0;
    do_reset();
    chk(load_req && sel_dev == 3'd1, "R5", "SD load", int'(sel_dev), 1);
    respond(0, 1);
    chk(polling && !load_req, "R5", "SD failure to serial", outcome(), 1);
    card_det_n = 1;

    // Timeout and report/expiry collision (R10)
    fuse_force_int = 1; tmo_limit = 16'd4;
    do_reset();
    k = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (load_req) begin k = i; break; end
    end
    chk(k == 5 && sel_dev == 3'd3, "R10", "timeout spacing", k, 5);
    repeat (4) @(negedge clk);
    chk(!load_req && !polling && !jump, "R10", "no early expiry", outcome(), 0);
    ld_done = 1; ld_ok = 1; ld_auth_ok = 1;
    @(negedge clk);
    ld_done = 0;
    chk(jump && sel_dev == 3'd3 && !polling, "R10", "report wins over expiry",
        int'(jump), 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule